// File: doc/BRIEF.md
# Line Latch with Polarity Steering

This block sits between the line capture register of a column driver and its per-channel digital-to-analog stage. While the next line of gray codes is being shifted into the capture register, the block holds the previous line steady for the outputs. A strobe pulse ends each line period. Its rising edge copies the whole capture register into the output latch and samples the polarity input. The outputs stay released while the strobe is high. On the falling edge every channel is driven again with the new codes.

Each channel carries three things out of the block: its latched 6-bit code, a bank-select bit that picks the upper or the lower reference voltage set, and a drive-enable bit. Adjacent channels always take opposite banks. The latched polarity bit decides which of the two gets the upper set. Two power-control pins are decoded into a four-level bias-mode code for the output amplifiers. A strobe that is too short sets a sticky error flag.

The controller has three states. ST_BLANK is entered at reset, with no channel driven. ST_RELEASE is held while the strobe is high, with every channel released. ST_DRIVE is held while the strobe is low after a line was applied. Transition T_CAPTURE moves from ST_BLANK or ST_DRIVE to ST_RELEASE on a strobe rising edge and loads the latch. Transition T_APPLY moves from ST_RELEASE to ST_DRIVE on a strobe falling edge.

Top module: `line_latch_steer`

## Requirements
- R1: When the strobe is seen rising at a clock edge, `lat_codes` equals the `cap_codes` value of that edge from the next clock on.
- R2: At every clock edge where the strobe is high, all `drive_en` bits are 0 from the next clock on.
- R3: At the clock edge where the strobe is first seen low after being high, all `drive_en` bits become 1 on the next clock and stay 1 until the strobe rises again.
- R4: `pol_in` is sampled at the strobe rising edge. For channel index i (0-based; index 0 is the first, odd-numbered channel), `bank_sel[i]` = sampled polarity XOR (i mod 2). A value of 0 selects the upper reference set and 1 selects the lower set.
- R5: Changes of `cap_codes` or `pol_in` at any clock edge other than a strobe rising edge do not change `lat_codes` or `bank_sel`.
- R6: `bias_mode` takes the following value one clock after the pins {`pwr_lo_pin`,`pwr_hi_pin`} are applied: 0/0 gives 3 (high), 1/0 gives 2 (middle), 0/1 gives 1 (normal), 1/1 gives 0 (low). 1/1 is the level of unconnected pins.
- R7: If the strobe falls after being high at fewer than MIN_HIGH (default 2) clock edges, `strobe_err` becomes 1 and stays 1 until reset. The latch is still loaded from that pulse.
- R8: After reset, `lat_codes` is 0, `drive_en` is 0, `strobe_err` is 0 and `bias_mode` is 0. `drive_en` stays 0 until the first strobe falling edge.
- R9: A strobe that is high for exactly MIN_HIGH clock edges does not set `strobe_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Line strobe, synchronous to clk |
| pol_in | input | 1 | Polarity input, sampled at strobe rise |
| cap_codes | input | NCH*CODE_W | Capture register contents; channel i occupies bits [i*CODE_W +: CODE_W] |
| pwr_lo_pin | input | 1 | Low-power control pin |
| pwr_hi_pin | input | 1 | High-power control pin |
| lat_codes | output | NCH*CODE_W | Latched gray codes, same packing as cap_codes |
| bank_sel | output | NCH | Per-channel reference bank (0 upper, 1 lower) |
| drive_en | output | NCH | Per-channel output switch enable |
| bias_mode | output | 2 | Decoded amplifier bias level |
| strobe_err | output | 1 | Sticky flag for a short strobe |

## Verification
A controller stuck in the wrong state shows up on `drive_en` one clock after the next strobe edge. The bench checks `drive_en` on the clock right after each rise and each fall, and again several clocks later. A polarity register sampled at the wrong time shows up as swapped `bank_sel` bits. The bench detects this because it changes `pol_in` and `cap_codes` while the strobe is high and then checks that the latched values still match the rising-edge values after the fall. A miscounted strobe width shows up on `strobe_err` one clock after the fall, because widths of one and two clocks are both exercised.

// File: rtl/lls_pkg.sv
package lls_pkg;

    typedef enum logic [1:0] {
        ST_BLANK   = 2'd0,
        ST_RELEASE = 2'd1,
        ST_DRIVE   = 2'd2
    } lls_state_e;

    typedef enum logic [1:0] {
        BIAS_LOW    = 2'd0,
        BIAS_NORMAL = 2'd1,
        BIAS_MIDDLE = 2'd2,
        BIAS_HIGH   = 2'd3
    } bias_mode_e;

endpackage

// File: rtl/lls_strobe_mon.sv
module lls_strobe_mon #(
    parameter int MIN_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise,
    output logic fall,
    output logic short_err
);
    localparam int CNT_W = $clog2(MIN_HIGH + 1);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_HIGH);

    logic             strb_q;
    logic [CNT_W-1:0] high_cnt;

    assign rise = strobe & ~strb_q;
    assign fall = ~strobe & strb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q    <= 1'b0;
            high_cnt  <= '0;
            short_err <= 1'b0;
        end else begin
            strb_q <= strobe;
            if (rise) begin
                high_cnt <= CNT_W'(1);
            end else if (strobe && (high_cnt < CNT_MIN)) begin
                high_cnt <= high_cnt + CNT_W'(1);
            end
            if (fall && (high_cnt < CNT_MIN)) begin
                short_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lls_fsm.sv
module lls_fsm
    import lls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       fall,
    output lls_state_e state,
    output logic       load,
    output logic       drive
);
    lls_state_e state_nx;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BLANK:   if (rise) state_nx = ST_RELEASE;   // T_CAPTURE
            ST_RELEASE: if (fall) state_nx = ST_DRIVE;     // T_APPLY
            ST_DRIVE:   if (rise) state_nx = ST_RELEASE;   // T_CAPTURE
            default:    state_nx = ST_BLANK;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BLANK;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        load  = 1'b0;
        drive = 1'b0;
        unique case (state)
            ST_BLANK:   load = rise;
            ST_RELEASE: load = 1'b0;
            ST_DRIVE: begin
                load  = rise;
                drive = 1'b1;
            end
            default: begin
                load  = 1'b0;
                drive = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lls_channel.sv
module lls_channel #(
    parameter int CODE_W = 6,
    parameter bit EVEN_CH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] cap_code,
    input  logic              pol_q,
    output logic [CODE_W-1:0] code,
    output logic              bank
);
    always_ff @(posedge clk) begin
        if (!rst_n)    code <= '0;
        else if (load) code <= cap_code;
    end

    // odd channels follow polarity directly, even channels take the opposite bank
    assign bank = pol_q ^ EVEN_CH;
endmodule

// File: rtl/lls_bias_dec.sv
module lls_bias_dec
    import lls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lo_pin,
    input  logic       hi_pin,
    output bias_mode_e mode
);
    bias_mode_e mode_nx;

    always_comb begin
        unique case ({lo_pin, hi_pin})
            2'b00:   mode_nx = BIAS_HIGH;
            2'b10:   mode_nx = BIAS_MIDDLE;
            2'b01:   mode_nx = BIAS_NORMAL;
            default: mode_nx = BIAS_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode <= BIAS_LOW;
        else        mode <= mode_nx;
    end
endmodule

// File: rtl/line_latch_steer.sv
module line_latch_steer
    import lls_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int CODE_W   = 6,
    parameter int MIN_HIGH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe,
    input  logic                  pol_in,
    input  logic [NCH*CODE_W-1:0] cap_codes,
    input  logic                  pwr_lo_pin,
    input  logic                  pwr_hi_pin,
    output logic [NCH*CODE_W-1:0] lat_codes,
    output logic [NCH-1:0]        bank_sel,
    output logic [NCH-1:0]        drive_en,
    output logic [1:0]            bias_mode,
    output logic                  strobe_err
);
    logic       rise, fall, load, drive, pol_q;
    lls_state_e state;
    bias_mode_e mode;

    lls_strobe_mon #(.MIN_HIGH(MIN_HIGH)) u_mon (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .rise(rise), .fall(fall), .short_err(strobe_err)
    );

    lls_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .state(state), .load(load), .drive(drive)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    pol_q <= 1'b0;
        else if (load) pol_q <= pol_in;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        lls_channel #(.CODE_W(CODE_W), .EVEN_CH(i % 2 == 1)) u_ch (
            .clk(clk), .rst_n(rst_n), .load(load),
            .cap_code(cap_codes[i*CODE_W +: CODE_W]),
            .pol_q(pol_q),
            .code(lat_codes[i*CODE_W +: CODE_W]),
            .bank(bank_sel[i])
        );
    end

    assign drive_en = {NCH{drive}};

    lls_bias_dec u_bias (
        .clk(clk), .rst_n(rst_n), .lo_pin(pwr_lo_pin), .hi_pin(pwr_hi_pin),
        .mode(mode)
    );
    assign bias_mode = mode;
endmodule

// File: rtl/lls_checker.sv
module lls_checker #(
    parameter int NCH    = 8,
    parameter int CODE_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  strobe,
    input logic                  pol_in,
    input logic [NCH*CODE_W-1:0] cap_codes,
    input logic                  pwr_lo_pin,
    input logic                  pwr_hi_pin,
    input logic [NCH*CODE_W-1:0] lat_codes,
    input logic [NCH-1:0]        bank_sel,
    input logic [NCH-1:0]        drive_en,
    input logic [1:0]            bias_mode,
    input logic                  strobe_err
);
    p_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !$past(strobe)) |=> (lat_codes == $past(cap_codes)));

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (drive_en == '0));

    p_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && $past(strobe)) |=> (drive_en == '1));

    p_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !$past(strobe)) |=> (bank_sel[0] == $past(pol_in)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && !$past(strobe)) |=> ($stable(lat_codes) && $stable(bank_sel)));

    p_bias_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_lo_pin && pwr_hi_pin) |=> (bias_mode == 2'd0));

    p_bias_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_lo_pin && !pwr_hi_pin) |=> (bias_mode == 2'd3));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_err |=> strobe_err);
endmodule

bind line_latch_steer lls_checker #(.NCH(NCH), .CODE_W(CODE_W)) u_lls_chk (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pol_in(pol_in),
    .cap_codes(cap_codes), .pwr_lo_pin(pwr_lo_pin), .pwr_hi_pin(pwr_hi_pin),
    .lat_codes(lat_codes), .bank_sel(bank_sel), .drive_en(drive_en),
    .bias_mode(bias_mode), .strobe_err(strobe_err)
);

// File: tb/line_latch_steer_bench.sv
module line_latch_steer_bench;
    localparam int NCH    = 8;
    localparam int CODE_W = 6;
    localparam int W      = NCH * CODE_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe = 1'b0;
    logic          pol_in = 1'b0;
    logic [W-1:0]  cap_codes = '0;
    logic          pwr_lo_pin = 1'b1;
    logic          pwr_hi_pin = 1'b1;
    logic [W-1:0]  lat_codes;
    logic [NCH-1:0] bank_sel;
    logic [NCH-1:0] drive_en;
    logic [1:0]    bias_mode;
    logic          strobe_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    line_latch_steer #(.NCH(NCH), .CODE_W(CODE_W), .MIN_HIGH(2)) u_line_latch_steer (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .pol_in(pol_in),
        .cap_codes(cap_codes), .pwr_lo_pin(pwr_lo_pin), .pwr_hi_pin(pwr_hi_pin),
        .lat_codes(lat_codes), .bank_sel(bank_sel), .drive_en(drive_en),
        .bias_mode(bias_mode), .strobe_err(strobe_err)
    );

    function automatic logic [W-1:0] pattern(input int seed);
        logic [W-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*CODE_W +: CODE_W] = CODE_W'((seed * 7 + i * 13 + 5) & 63);
        return v;
    endfunction

    function automatic logic [NCH-1:0] banks(input logic pol);
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = pol ^ (i % 2 == 1);
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; strobe = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one line period: strobe high for hi clocks, polarity pol
    task automatic run_line(input int seed, input logic pol, input int hi, input logic exp_err);
        logic [W-1:0] exp_codes;
        exp_codes = pattern(seed);
        @(negedge clk);
        cap_codes = exp_codes; pol_in = pol; strobe = 1'b1;
        @(negedge clk);
        chk("R1 codes latched at rise", 64'(lat_codes), 64'(exp_codes));
        chk("R2 released while strobe high", 64'(drive_en), 64'(0));
        chk("R4 bank pattern", 64'(bank_sel), 64'(banks(pol)));
        cap_codes = pattern(seed + 11); pol_in = ~pol;
        repeat (hi - 1) @(negedge clk);
        if (hi > 1) chk("R2 still released", 64'(drive_en), 64'(0));
        strobe = 1'b0;
        @(negedge clk);
        chk("R3 driven after fall", 64'(drive_en), 64'({NCH{1'b1}}));
        chk("R5 codes ignore late change", 64'(lat_codes), 64'(exp_codes));
        chk("R5 bank ignores late polarity", 64'(bank_sel), 64'(banks(pol)));
        chk(exp_err ? "R7 short strobe flagged" : "R9 full strobe no flag", 64'(strobe_err), 64'(exp_err));
        repeat (3) @(negedge clk);
        chk("R3 drive held until next rise", 64'(drive_en), 64'({NCH{1'b1}}));
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R8 codes zero", 64'(lat_codes), 64'(0));
        chk("R8 drive zero", 64'(drive_en), 64'(0));
        chk("R8 err zero", 64'(strobe_err), 64'(0));
        chk("R8 bias low", 64'(bias_mode), 64'(0));
        repeat (3) @(negedge clk);
        chk("R8 drive zero before first strobe", 64'(drive_en), 64'(0));
    endtask

    task automatic t_bias();
        logic [1:0] exp_tab [4];
        exp_tab[0] = 2'd3; exp_tab[1] = 2'd1; exp_tab[2] = 2'd2; exp_tab[3] = 2'd0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pwr_lo_pin = k[1]; pwr_hi_pin = k[0];
            @(negedge clk);
            chk("R6 bias decode", 64'(bias_mode), 64'(exp_tab[k]));
        end
        pwr_lo_pin = 1'b1; pwr_hi_pin = 1'b1;
    endtask

    task automatic t_short();
        run_line(40, 1'b0, 1, 1'b1);   // R7: one-clock strobe, latch still updated
        run_line(41, 1'b1, 3, 1'b1);   // R7: flag stays set
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        run_line(1, 1'b0, 3, 1'b0);
        run_line(2, 1'b1, 2, 1'b0);
        run_line(3, 1'b0, 5, 1'b0);
        t_bias();
        t_short();
        t_reset();
        run_line(9, 1'b1, 2, 1'b0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule